// File: doc/BRIEF.md
# DRAM Power-Up Initialization Sequencer

This block drives the command pins of a synchronous DRAM from power-on until the device can take normal traffic. When `start` is pulsed, it first checks the configuration inputs. If they are valid, it holds the bus at NOP for a programmable settling interval, with clock enable and the data mask held high. It then closes every bank with a single precharge-all command. After that it runs a refresh phase and a mode-set phase. The refresh phase is a programmable number of auto-refresh commands (at least two). The mode-set phase is a single mode-register write, whose word is built from the burst length, burst type, read latency and write-burst inputs. Both phases must always happen, and `cfg_mode_first` chooses which comes first.

Each command is followed by a fixed number of quiet cycles:
- precharge period `T_RP` after the precharge-all;
- row-cycle time `T_RC` after each refresh;
- recovery time `T_MRD` after the mode write.

When the last of these windows expires, `ready` rises and stays high. A reserved latency or burst-length code at start raises `err` instead, and no command is issued.

Top module: `dram_init_seq`

## Requirements
- R1: Out of reset, the bus shows NOP and `cke`=1, `dqm`=1, `ready`=0 and `err`=0. NOP means `cs_n`=0 with `ras_n`=`cas_n`=`we_n`=1.
- R2: The cycle after a valid start is counted as cycle 0. For cycles 0 to `WAIT_CYC`-1 the bus stays NOP with `cke` and `dqm` high. Precharge-all is issued in cycle `WAIT_CYC` with ras/cas/we = 0/1/0 and `addr[10]`=1.
- R3: The command after the precharge-all comes exactly `T_RP` cycles after it.
- R4: Auto-refresh (ras/cas/we = 0/0/1) is issued exactly `N_REF` times. Each refresh is followed by exactly `T_RC` cycles before the next command or before ready.
- R5: With `cfg_mode_first`=0 the refreshes come before the mode write. With `cfg_mode_first`=1 the mode write comes first.
- R6: The mode write (ras/cas/we = 0/0/0) carries this address word:
  - bits [2:0] = burst length code;
  - bit [3] = burst type (1 = interleave);
  - bits [6:4] = latency code;
  - bits [8:7] = 0;
  - bit [9] = single-beat write enable;
  - bit [10] and every higher address bit = 0;
  - `ba` = 0.
- R7: If the mode write is the last command, `ready` rises exactly `T_MRD` cycles after it. Otherwise `ready` rises `T_RC` cycles after the last refresh. It then stays high, and no further command is issued.
- R8: A latency code other than 010 or 011 at start sets `err` in the next cycle. No command is issued afterwards, and `ready` stays 0.
- R9: Burst length codes 100, 101 and 110 at start set `err`, as does 111 with interleave. No command follows.
- R10: The configuration is captured at start. Changes to the config inputs during the sequence do not change the mode word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the sequence (sampled while idle) |
| cfg_burst_len | input | 3 | Burst length code |
| cfg_interleave | input | 1 | Burst type, 1 = interleave |
| cfg_latency | input | 3 | Read latency code |
| cfg_single_wr | input | 1 | Single-beat write enable |
| cfg_mode_first | input | 1 | 1 = mode write before refreshes |
| cke | output | 1 | Clock enable to DRAM |
| dqm | output | 1 | Data mask to DRAM |
| cs_n | output | 1 | Chip select |
| ras_n | output | 1 | Row strobe |
| cas_n | output | 1 | Column strobe |
| we_n | output | 1 | Write enable |
| addr | output | ADDR_W | Address bus |
| ba | output | BA_W | Bank select |
| ready | output | 1 | Initialization complete |
| err | output | 1 | Reserved configuration rejected |

## Verification
The hardest situation to reach from the ports is a change of configuration after start has been accepted. The mode word must still show the values captured at start, and this can only be seen many cycles later, when the mode write appears. The stimulus flips every config input early in the settling interval and leaves them flipped. The scoreboard holds the mode word built from the original inputs. The bench also runs both phase orders, so that the mode write falls both right after the precharge and just before ready.

// File: rtl/dram_init_seq.sv
module dram_init_seq #(
  parameter int WAIT_CYC = 20000,
  parameter int T_RP     = 3,
  parameter int T_RC     = 7,
  parameter int T_MRD    = 2,
  parameter int N_REF    = 2,
  parameter int ADDR_W   = 11,
  parameter int BA_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        cfg_burst_len,
  input  logic              cfg_interleave,
  input  logic [2:0]        cfg_latency,
  input  logic              cfg_single_wr,
  input  logic              cfg_mode_first,
  output logic              cke,
  output logic              dqm,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba,
  output logic              ready,
  output logic              err
);
  localparam int M1 = (WAIT_CYC > T_RC) ? WAIT_CYC : T_RC;
  localparam int M2 = (M1 > T_RP) ? M1 : T_RP;
  localparam int M3 = (M2 > T_MRD) ? M2 : T_MRD;
  localparam int CW = $clog2(M3 + 1);
  localparam int RW = $clog2(N_REF + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_PRE, S_REF, S_MRS, S_GAP, S_DONE, S_ERR
  } st_t;

  st_t            st, nxt;
  logic [CW-1:0]  cnt;
  logic [RW-1:0]  refs;
  logic           mrs_done, mode_first;
  logic [9:0]     mode_q;
  logic           cfg_ok;

  assign cfg_ok = (cfg_latency == 3'b010 || cfg_latency == 3'b011) &&
                  (cfg_burst_len <= 3'b011 ||
                   (cfg_burst_len == 3'b111 && !cfg_interleave));

  always_comb begin
    if (!mrs_done && (mode_first || refs == RW'(N_REF))) nxt = S_MRS;
    else if (refs != RW'(N_REF))                         nxt = S_REF;
    else                                                 nxt = S_DONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      refs       <= '0;
      mrs_done   <= 1'b0;
      mode_first <= 1'b0;
      mode_q     <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          if (cfg_ok) begin
            mode_q     <= {cfg_single_wr, 2'b00, cfg_latency,
                           cfg_interleave, cfg_burst_len};
            mode_first <= cfg_mode_first;
            refs       <= '0;
            mrs_done   <= 1'b0;
            cnt        <= CW'(WAIT_CYC - 1);
            st         <= S_WAIT;
          end else begin
            st <= S_ERR;
          end
        end
        S_WAIT: if (cnt == '0) st <= S_PRE;
                else cnt <= cnt - 1'b1;
        S_PRE: begin
          cnt <= CW'(T_RP - 2);
          st  <= S_GAP;
        end
        S_REF: begin
          refs <= refs + 1'b1;
          cnt  <= CW'(T_RC - 2);
          st   <= S_GAP;
        end
        S_MRS: begin
          mrs_done <= 1'b1;
          cnt      <= CW'(T_MRD - 2);
          st       <= S_GAP;
        end
        S_GAP: if (cnt == '0) st <= nxt;
               else cnt <= cnt - 1'b1;
        default: st <= st;
      endcase
    end
  end

  assign cke   = 1'b1;
  assign dqm   = 1'b1;
  assign cs_n  = 1'b0;
  assign ras_n = !(st == S_PRE || st == S_REF || st == S_MRS);
  assign cas_n = !(st == S_REF || st == S_MRS);
  assign we_n  = !(st == S_PRE || st == S_MRS);
  assign addr  = (st == S_MRS) ? {{(ADDR_W-10){1'b0}}, mode_q} :
                 (st == S_PRE) ? ADDR_W'(1024) : '0;
  assign ba    = '0;
  assign ready = (st == S_DONE);
  assign err   = (st == S_ERR);
endmodule

// File: rtl/dram_init_seq_chk.sv
module dram_init_seq_chk #(
  parameter int ADDR_W = 11,
  parameter int BA_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic [BA_W-1:0]   ba,
  input logic              ready,
  input logic              err
);
  logic is_nop, is_pre, is_mrs;
  assign is_nop = ras_n && cas_n && we_n;
  assign is_pre = !ras_n && cas_n && !we_n;
  assign is_mrs = !ras_n && !cas_n && !we_n;

  a_r2_pre_all: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> addr[10]);
  a_r6_mrs_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    is_mrs |-> (ba == '0 && addr[10] == 1'b0 && addr[8:7] == 2'b00));
  a_r3_command_gap: assert property (@(posedge clk) disable iff (!rst_n)
    !is_nop |=> is_nop);
  a_r7_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);
  a_r7_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> is_nop);
  a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (is_nop && !ready));
endmodule

bind dram_init_seq dram_init_seq_chk #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .addr(addr), .ba(ba), .ready(ready), .err(err));

// File: tb/dram_init_seq_tb.sv
module dram_init_seq_tb;
  localparam int W = 30, TRP = 3, TRC = 7, TMRD = 2, NREF = 2, AW = 11;

  logic clk = 0, rst_n = 0, start = 0;
  logic [2:0] bl = 0, lat = 0;
  logic bt = 0, sw = 0, mf = 0;
  logic cke, dqm, cs_n, ras_n, cas_n, we_n, ready, err;
  logic [AW-1:0] addr;
  logic [1:0] ba;

  always #5 clk = ~clk;

  dram_init_seq #(.WAIT_CYC(W), .T_RP(TRP), .T_RC(TRC), .T_MRD(TMRD),
                  .N_REF(NREF), .ADDR_W(AW), .BA_W(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_burst_len(bl),
    .cfg_interleave(bt), .cfg_latency(lat), .cfg_single_wr(sw),
    .cfg_mode_first(mf), .cke(cke), .dqm(dqm), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .addr(addr), .ba(ba), .ready(ready), .err(err));

  typedef struct packed {
    int            t;
    logic [2:0]    cmd;
    logic [AW-1:0] a;
  } exp_t;

  exp_t q[$];
  int errors = 0, checks = 0, cyc = 0, base = 0;
  bit active = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (active && rst_n && {ras_n, cas_n, we_n} != 3'b111) begin
      if (q.size() == 0) begin
        chk(0, "R7/R8/R9 unexpected command", {ras_n, cas_n, we_n}, 3'b111);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(cyc - base == e.t, "R3/R4 command time", cyc - base, e.t);
        chk({ras_n, cas_n, we_n} == e.cmd, "R5 command order", {ras_n, cas_n, we_n}, e.cmd);
        chk(addr == e.a && ba == 2'b00, "R2/R6 address word", {ba, addr}, e.a);
      end
    end
  end

  task automatic do_reset();
    active = 0;
    rst_n = 0;
    start = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cke && dqm && !cs_n && ras_n && cas_n && we_n && !ready && !err,
        "R1 reset state", {cke, dqm, cs_n, ras_n, cas_n, we_n, ready, err}, 8'b11011100);
  endtask

  task automatic pulse_start();
    start = 1;
    @(negedge clk);
    start = 0;
    base = cyc;
    active = 1;
  endtask

  task automatic run(input logic [2:0] l, input logic i, input logic [2:0] c,
                     input logic s, input logic m, input bit scramble);
    int t, rdy;
    bit quiet;
    logic [AW-1:0] mw;
    exp_t e;
    do_reset();
    bl = l; bt = i; lat = c; sw = s; mf = m;
    mw = AW'({s, 2'b00, c, i, l});
    t = W;
    e.t = t; e.cmd = 3'b010; e.a = AW'(1024); q.push_back(e);
    t += TRP;
    if (m) begin
      e.t = t; e.cmd = 3'b000; e.a = mw; q.push_back(e);
      t += TMRD;
    end
    for (int k = 0; k < NREF; k++) begin
      e.t = t; e.cmd = 3'b001; e.a = '0; q.push_back(e);
      t += TRC;
    end
    if (!m) begin
      e.t = t; e.cmd = 3'b000; e.a = mw; q.push_back(e);
      t += TMRD;
    end
    rdy = t;
    pulse_start();
    quiet = 1;
    for (int r = 0; r <= rdy + 6; r++) begin
      if (r > 0) @(negedge clk);
      if (r == 2 && scramble) begin // R10: flip inputs after capture
        bl = ~l; bt = ~i; lat = ~c; sw = ~s; mf = ~m;
      end
      if (cyc - base < W)
        quiet &= (cke && dqm && ras_n && cas_n && we_n);
      if (cyc - base == rdy - 1)
        chk(!ready, "R7 ready early", ready, 0);
      if (cyc - base == rdy)
        chk(ready && !err, "R7 ready time", ready, 1);
    end
    chk(quiet, "R2 settling NOP", quiet, 1);
    chk(ready, "R7 ready sticky", ready, 1);
    chk(q.size() == 0, "R4/R5 missing commands", q.size(), 0);
    q.delete();
  endtask

  task automatic run_bad(input logic [2:0] l, input logic i, input logic [2:0] c, input string req);
    do_reset();
    bl = l; bt = i; lat = c; sw = 0; mf = 0;
    pulse_start();
    chk(err && !ready, req, {err, ready}, 2'b10);
    repeat (W + TRP + 4 * TRC) @(negedge clk);
    chk(err && !ready && ras_n && cas_n && we_n, req, {err, ready, ras_n, cas_n, we_n}, 5'b10111);
  endtask

  bit done = 0;
  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    run(3'b011, 0, 3'b011, 0, 0, 0);           // R5 refresh first, BL8 seq
    run(3'b111, 0, 3'b010, 1, 1, 1);           // R5 mode first, R10 scramble
    run(3'b010, 1, 3'b010, 0, 0, 1);           // R6 interleave, R10
    run(3'b000, 1, 3'b011, 1, 1, 0);           // R6 single write
    run_bad(3'b011, 0, 3'b100, "R8 reserved latency 100");
    run_bad(3'b001, 0, 3'b000, "R8 reserved latency 000");
    run_bad(3'b111, 1, 3'b010, "R9 interleave full page");
    run_bad(3'b101, 0, 3'b011, "R9 reserved length 101");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule